// File: doc/BRIEF.md
# Keyed Unlock Guard for a Clock Control Register

This block sits in front of a two-byte clock control register and decides whether a byte write may land. Each byte has its own two-value unlock key. Software must write the first key value and then the second key value to that byte on consecutive instruction cycles. The write that follows on the very next instruction cycle is the only one the register accepts. That write may replace the whole byte or set, clear or toggle a single bit.

Every decision is made on an instruction-cycle tick. Clock edges without a tick leave the block untouched. Both bytes have independent sequencers. Each sequencer falls back to its locked idle state when a wrong value arrives, when a write goes to the other byte, or when a tick passes with no write to its byte. Writes that arrive while a byte is locked are dropped. An optional sticky flag records every dropped write.

Top module: `osc_write_guard`

## Requirements
- R1: After reset, `reg_q` equals the `RESET_VAL` parameter (default 0x0000), `open_lo` and `open_hi` are 0, and `violation` is 0.
- R2: On ticked low-byte plain writes, the value 0x46 followed on the next tick by 0x57 raises `open_lo`. Neither key write changes `reg_q`.
- R3: On ticked high-byte plain writes, the value 0x78 followed on the next tick by 0x9A raises `open_hi`. Neither key write changes `reg_q`.
- R4: An open window lasts exactly one tick. A write to that byte on that tick is applied, and the window is closed after the tick whatever happens on it.
- R5: A sequence is broken, and that byte returns to locked idle, by any of these on the tick after the first key: a different value, a bit operation, a write to the other byte, or a tick with no write. Repeating the first key also breaks the sequence; it does not re-arm.
- R6: A write to a byte whose window is not open leaves that byte of `reg_q` unchanged.
- R7: An open window on one byte never lets a write reach the other byte, and such a write closes the open window.
- R8: `wr_op` selects the kind of write: 00 replaces the byte with `wr_data`; 01 sets, 10 clears and 11 toggles the bit whose index is in `wr_data[2:0]`. Each kind takes effect only inside an open window.
- R9: Clock edges with `tick` low change no output and do not count as intervening cycles. A key sequence spread across such edges still unlocks.
- R10: With `HAS_VIOL`=1, `violation` rises one clock after a ticked write to a byte that is neither an accepted key step nor an applied write. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle qualifier; the bus is sampled only when high |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_op | input | 2 | Write kind: 00 byte, 01 set bit, 10 clear bit, 11 toggle bit |
| wr_data | input | BYTE_W | Write value, or bit index in the low bits |
| reg_q | output | 2*BYTE_W | Protected register contents |
| open_lo | output | 1 | Low byte window open for the next tick |
| open_hi | output | 1 | High byte window open for the next tick |
| violation | output | 1 | Sticky dropped-write flag |

## Verification
Every output is registered. The effect of a ticked write appears one clock after the edge that sampled it: the register contents, the window flags and the violation flag all change together. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. At that point it compares every output against a reference model that advances exactly one step per driven vector. Non-ticked vectors advance the model with no change, which checks that idle edges are ignored in the same cycle.

// File: rtl/owg_pkg.sv
package owg_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b00,
      OP_SET   = 2'b01,
      OP_CLR   = 2'b10,
      OP_TGL   = 2'b11
   } owg_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ARMED = 2'b01,
      ST_OPEN  = 2'b10
   } owg_state_e;

endpackage

// File: rtl/owg_upd.sv
// Computes the next byte value for a guarded write of any kind.
module owg_upd
   import owg_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] cur_i,
   input  logic [1:0]        op_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic [BYTE_W-1:0] nxt_o
);

   localparam int IDX_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] mask;

   always_comb begin
      mask = '0;
      mask[data_i[IDX_W-1:0]] = 1'b1;
      case (owg_op_e'(op_i))
         OP_WRITE: nxt_o = data_i;
         OP_SET:   nxt_o = cur_i | mask;
         OP_CLR:   nxt_o = cur_i & ~mask;
         default:  nxt_o = cur_i ^ mask;
      endcase
   end

endmodule

// File: rtl/owg_seq.sv
// Per-byte key sequencer: idle -> armed -> open -> idle.
module owg_seq
   import owg_pkg::*;
#(
   parameter int                BYTE_W = 8,
   parameter logic [BYTE_W-1:0] KEY_A  = '0,
   parameter logic [BYTE_W-1:0] KEY_B  = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              sel_i,
   input  logic              plain_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              open_o,
   output logic              apply_o,
   output logic              viol_o
);

   owg_state_e state_q, state_d;
   logic       hit_a, hit_b;

   assign hit_a = sel_i && plain_i && (data_i == KEY_A);
   assign hit_b = sel_i && plain_i && (data_i == KEY_B);

   always_comb begin
      state_d = state_q;
      apply_o = 1'b0;
      viol_o  = 1'b0;
      if (tick_i) begin
         unique case (state_q)
            ST_IDLE: begin
               state_d = hit_a ? ST_ARMED : ST_IDLE;
               viol_o  = sel_i && !hit_a;
            end
            ST_ARMED: begin
               state_d = hit_b ? ST_OPEN : ST_IDLE;
               viol_o  = sel_i && !hit_b;
            end
            ST_OPEN: begin
               state_d = ST_IDLE;
               apply_o = sel_i;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign open_o = (state_q == ST_OPEN);

endmodule

// File: rtl/osc_write_guard.sv
module osc_write_guard
   import owg_pkg::*;
#(
   parameter int                  BYTE_W    = 8,
   parameter logic [BYTE_W-1:0]   KEY_LO_A  = 8'h46,
   parameter logic [BYTE_W-1:0]   KEY_LO_B  = 8'h57,
   parameter logic [BYTE_W-1:0]   KEY_HI_A  = 8'h78,
   parameter logic [BYTE_W-1:0]   KEY_HI_B  = 8'h9A,
   parameter logic [2*BYTE_W-1:0] RESET_VAL = '0,
   parameter bit                  HAS_VIOL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                wr_en,
   input  logic                wr_hi,
   input  logic [1:0]          wr_op,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [2*BYTE_W-1:0] reg_q,
   output logic                open_lo,
   output logic                open_hi,
   output logic                violation
);

   localparam int N_BYTES = 2;

   initial begin
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0)
         $fatal(1, "osc_write_guard: BYTE_W must be a power of two >= 2");
   end

   logic [N_BYTES-1:0][BYTE_W-1:0] byte_q;
   logic [N_BYTES-1:0]             open_v;
   logic [N_BYTES-1:0]             viol_v;
   logic                           plain;

   assign plain = (wr_op == OP_WRITE);

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      localparam logic [BYTE_W-1:0] KA = (b == 0) ? KEY_LO_A : KEY_HI_A;
      localparam logic [BYTE_W-1:0] KB = (b == 0) ? KEY_LO_B : KEY_HI_B;

      logic              sel;
      logic              apply;
      logic [BYTE_W-1:0] nxt;
      logic [BYTE_W-1:0] q;

      assign sel = wr_en && (wr_hi == 1'(b));

      owg_seq #(
         .BYTE_W (BYTE_W),
         .KEY_A  (KA),
         .KEY_B  (KB)
      ) u_seq (
         .clk_i   (clk),
         .rst_ni  (rst_n),
         .tick_i  (tick),
         .sel_i   (sel),
         .plain_i (plain),
         .data_i  (wr_data),
         .open_o  (open_v[b]),
         .apply_o (apply),
         .viol_o  (viol_v[b])
      );

      owg_upd #(
         .BYTE_W (BYTE_W)
      ) u_upd (
         .cur_i  (q),
         .op_i   (wr_op),
         .data_i (wr_data),
         .nxt_o  (nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= RESET_VAL[b*BYTE_W +: BYTE_W];
         else if (apply) q <= nxt;
      end

      assign byte_q[b] = q;
   end

   if (HAS_VIOL) begin : g_viol
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (|viol_v)  flag_q <= 1'b1;
      end
      assign violation = flag_q;
   end else begin : g_no_viol
      assign violation = 1'b0;
   end

   assign reg_q   = byte_q;
   assign open_lo = open_v[0];
   assign open_hi = open_v[1];

endmodule

// File: rtl/owg_chk.sv
module owg_chk #(
   parameter int                BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] KEY_LO_B = 8'h57,
   parameter logic [BYTE_W-1:0] KEY_HI_B = 8'h9A
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                wr_en,
   input logic                wr_hi,
   input logic [1:0]          wr_op,
   input logic [BYTE_W-1:0]   wr_data,
   input logic [2*BYTE_W-1:0] reg_q,
   input logic                open_lo,
   input logic                open_hi,
   input logic                violation
);

   p_lo_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_lo) |-> $past(tick && wr_en && !wr_hi && wr_op == 2'b00 && wr_data == KEY_LO_B));

   p_hi_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_hi) |-> $past(tick && wr_en && wr_hi && wr_op == 2'b00 && wr_data == KEY_HI_B));

   p_window_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      open_lo && tick |=> !open_lo);

   p_window_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      open_hi && tick |=> !open_hi);

   p_locked_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !open_lo |=> $stable(reg_q[BYTE_W-1:0]));

   p_locked_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !open_hi |=> $stable(reg_q[2*BYTE_W-1:BYTE_W]));

   p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({open_hi, open_lo}));

   p_idle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(reg_q) && $stable(open_lo) && $stable(open_hi) && $stable(violation));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

endmodule

bind osc_write_guard owg_chk #(
   .BYTE_W   (BYTE_W),
   .KEY_LO_B (KEY_LO_B),
   .KEY_HI_B (KEY_HI_B)
) i_owg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .wr_hi     (wr_hi),
   .wr_op     (wr_op),
   .wr_data   (wr_data),
   .reg_q     (reg_q),
   .open_lo   (open_lo),
   .open_hi   (open_hi),
   .violation (violation)
);

// File: tb/test_osc_write_guard.sv
module test_osc_write_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_hi = 1'b0;
   logic [1:0]  wr_op = 2'b00;
   logic [7:0]  wr_data = 8'h00;
   logic [15:0] reg_q;
   logic        open_lo, open_hi, violation;

   int n_vec = 0;
   int n_bad = 0;

   logic [1:0] m_st [2];
   logic [7:0] m_byte [2];
   bit         m_viol;

   always #2 clk = ~clk;

   osc_write_guard i_osc_write_guard (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_hi(wr_hi),
      .wr_op(wr_op), .wr_data(wr_data), .reg_q(reg_q),
      .open_lo(open_lo), .open_hi(open_hi), .violation(violation)
   );

   function automatic logic [7:0] key_a(int b);
      return (b == 0) ? 8'h46 : 8'h78;
   endfunction

   function automatic logic [7:0] key_b(int b);
      return (b == 0) ? 8'h57 : 8'h9A;
   endfunction

   function automatic logic [7:0] upd(logic [7:0] cur, logic [1:0] op, logic [7:0] d);
      logic [7:0] m;
      m = 8'h01 << d[2:0];
      case (op)
         2'b00:   return d;
         2'b01:   return cur | m;
         2'b10:   return cur & ~m;
         default: return cur ^ m;
      endcase
   endfunction

   // state codes: 0 idle, 1 armed, 2 open
   function automatic logic [1:0] nxt_st(logic [1:0] st, bit sel, bit plain, logic [7:0] d, int b);
      case (st)
         2'd0:    return (sel && plain && d == key_a(b)) ? 2'd1 : 2'd0;
         2'd1:    return (sel && plain && d == key_b(b)) ? 2'd2 : 2'd0;
         default: return 2'd0;
      endcase
   endfunction

   function automatic bit is_viol(logic [1:0] st, bit sel, bit plain, logic [7:0] d, int b);
      if (!sel || st == 2'd2) return 1'b0;
      if (st == 2'd0) return !(plain && d == key_a(b));
      return !(plain && d == key_b(b));
   endfunction

   task automatic compare(string tag);
      logic [15:0] exp_q;
      exp_q = {m_byte[1], m_byte[0]};
      n_vec++;
      if (reg_q !== exp_q || open_lo !== (m_st[0] == 2'd2) ||
          open_hi !== (m_st[1] == 2'd2) || violation !== m_viol) begin
         n_bad++;
         $display("FAIL %s: actual reg=%h lo=%b hi=%b viol=%b expected reg=%h lo=%b hi=%b viol=%b",
                  tag, reg_q, open_lo, open_hi, violation,
                  exp_q, m_st[0] == 2'd2, m_st[1] == 2'd2, m_viol);
      end
   endtask

   task automatic step(bit tk, bit en, bit hi, logic [1:0] op, logic [7:0] d, string tag);
      @(negedge clk);
      tick = tk; wr_en = en; wr_hi = hi; wr_op = op; wr_data = d;
      @(posedge clk);
      #1;
      if (tk) begin
         for (int b = 0; b < 2; b++) begin
            bit sel;
            sel = en && (hi == b[0]);
            if (is_viol(m_st[b], sel, op == 2'b00, d, b)) m_viol = 1'b1;
            if (m_st[b] == 2'd2 && sel) m_byte[b] = upd(m_byte[b], op, d);
            m_st[b] = nxt_st(m_st[b], sel, op == 2'b00, d, b);
         end
      end
      compare(tag);
   endtask

   task automatic unlock(bit hi, string tag);
      step(1, 1, hi, 2'b00, key_a(hi ? 1 : 0), tag);
      step(1, 1, hi, 2'b00, key_b(hi ? 1 : 0), tag);
   endtask

   function automatic logic [7:0] pick();
      case ($urandom_range(0, 4))
         0:       return 8'h46;
         1:       return 8'h57;
         2:       return 8'h78;
         3:       return 8'h9A;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_st[0] = 0; m_st[1] = 0; m_byte[0] = 0; m_byte[1] = 0; m_viol = 0;
      repeat (3) @(posedge clk);
      #1;
      compare("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 2'b00, 8'h00, "R1 after release");

      // R2 low unlock and write
      step(1, 1, 0, 2'b00, 8'h46, "R2 first key no change");
      step(1, 1, 0, 2'b00, 8'h57, "R2 second key opens");
      step(1, 1, 0, 2'b00, 8'hAB, "R4 write lands and closes");
      // R3 high unlock and write
      unlock(1, "R3 high keys");
      step(1, 1, 1, 2'b00, 8'hCD, "R3 high write lands");
      step(0, 0, 0, 2'b00, 8'h00, "R10 no violation yet");

      // R4 window expires after an idle tick
      unlock(0, "R4 keys");
      step(1, 0, 0, 2'b00, 8'h00, "R4 idle tick closes");
      step(1, 1, 0, 2'b00, 8'h11, "R4 late write dropped R10");

      // R5 breaks
      step(1, 1, 0, 2'b00, 8'h46, "R5 key a");
      step(1, 0, 0, 2'b00, 8'h00, "R5 idle tick breaks");
      step(1, 1, 0, 2'b00, 8'h57, "R5 key b alone");
      step(1, 1, 0, 2'b00, 8'h22, "R5 write dropped");
      step(1, 1, 0, 2'b00, 8'h46, "R5 key a");
      step(1, 1, 0, 2'b00, 8'h46, "R5 repeated key a breaks");
      step(1, 1, 0, 2'b00, 8'h57, "R5 key b after repeat");
      step(1, 1, 0, 2'b00, 8'h33, "R5 write dropped");
      step(1, 1, 1, 2'b00, 8'h78, "R5 hi key a");
      step(1, 1, 1, 2'b01, 8'h9A, "R5 bit op breaks");
      step(1, 1, 1, 2'b00, 8'h44, "R5 hi write dropped");

      // R9 gaps without tick
      step(1, 1, 0, 2'b00, 8'h46, "R9 key a");
      step(0, 1, 0, 2'b00, 8'h99, "R9 untick write ignored");
      step(0, 1, 1, 2'b11, 8'h05, "R9 untick write ignored");
      step(1, 1, 0, 2'b00, 8'h57, "R9 key b opens");
      step(0, 0, 0, 2'b00, 8'h00, "R9 window held");
      step(1, 1, 0, 2'b00, 8'h5A, "R9 write lands");

      // R7 independence
      unlock(0, "R7 low keys");
      step(1, 1, 1, 2'b00, 8'hEE, "R7 high write blocked and low closed");
      step(1, 1, 0, 2'b00, 8'h77, "R7 low write dropped");

      // R8 bit operations
      unlock(1, "R8 keys");
      step(1, 1, 1, 2'b01, 8'h03, "R8 set bit 3");
      unlock(0, "R8 keys");
      step(1, 1, 0, 2'b11, 8'h00, "R8 toggle bit 0");
      unlock(0, "R8 keys");
      step(1, 1, 0, 2'b10, 8'hF6, "R8 clear bit 6");
      step(1, 1, 0, 2'b01, 8'h01, "R8 bit op locked dropped R6");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 25) begin
            bit hi;
            hi = 1'($urandom_range(0, 1));
            step(1, 1, hi, 2'b00, key_a(hi ? 1 : 0), "R2/R3 random burst");
            if ($urandom_range(0, 3) == 0)
               step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 2'($urandom), pick(), "R5 random disturb");
            step(1, 1, hi, 2'b00, key_b(hi ? 1 : 0), "R2/R3 random burst");
            if ($urandom_range(0, 3) == 0)
               step(0, 1, 1'($urandom_range(0, 1)), 2'($urandom), pick(), "R9 random gap");
            step(1, 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) == 0 ? !hi : hi),
                 2'($urandom), 8'($urandom), "R8 random guarded write");
         end else begin
            step(1'($urandom_range(0, 6) != 0), 1'($urandom_range(0, 4) != 0),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b00,
                 pick(), "R6 random single");
         end
      end

      // reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      m_st[0] = 0; m_st[1] = 0; m_byte[0] = 0; m_byte[1] = 0; m_viol = 0;
      @(posedge clk);
      #1;
      compare("R1 second reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule